// File: doc/BRIEF.md
# CF-ATA Address Mode Remapper

This block sits between a card's host-side access port and an ATA task-file. It takes an access offset, already made relative to the card's common-memory or I/O window, and turns it into an eight-entry task-file register index plus read and write strobes. Which translation applies is chosen by a two-bit addressing-mode input: flat memory mapping, a contiguous sixteen-byte I/O block, or the legacy primary or secondary command/control port pairs.

After translation, the access is steered. Even and odd data offsets become 16-bit data-port transfers. The error/features offset goes to task-file register 1. The alternate-status/device-control offset is handled locally. Reads return the drive status, and writes load a device-control register that can fire a soft-reset pulse. A read of the device-address offset returns a synthesized byte built from the drive-select bit. Everything else is forwarded to the task-file register named by the low three bits of the translated offset.

A write on that forwarding path, made while the power-down status input is set, produces a one-cycle wake pulse. The status owner uses it to set its ready flag and clear power-down.

Top module: `cfr_remap`

## Requirements
- R1: In mode 0, offsets 0x400 to 0x7FF translate to 0 (the data port). Every other offset passes through unchanged.
- R2: In mode 1, the translated offset is the low four bits of the access offset.
- R3: In mode 2, offsets 0x1F0-0x1FF translate to offset-0x1F0 and offsets 0x3F0-0x3FF translate to offset-0x3E8.
- R4: In mode 3, offsets 0x170-0x17F translate to offset-0x170 and offsets 0x370-0x37F translate to offset-0x368.
- R5: A translated offset of 0 or 8 pulses `tf_data_rd` (read) or `tf_data_wr` (write) with no register strobe. Read data is `tf_rdata` and `tf_wdata` equals `acc_wdata`.
- R6: A translated offset of 0xD reads or writes task-file register 1 through `tf_rd`/`tf_wr` with `tf_reg`=1.
- R7: A read at translated offset 0xE returns `drv_status` when `drv_present` is 1 and 0 otherwise, and raises no task-file strobe.
- R8: A write at translated offset 0xE raises no task-file strobe and loads `devctl` from `acc_wdata[7:0]` on the next cycle. If bit 2 (value 0x04) is set, `soft_rst` is high for exactly that one cycle.
- R9: A read at translated offset 0xF raises no strobe and returns 0xC2 OR ((inverted drive-select shifted left 2) AND 0x3C): 0xFE when `drv_sel`=0 and 0xFA when `drv_sel`=1.
- R10: Every other translated offset, including writes at 0xF, is forwarded with `tf_reg` equal to its low three bits. Reads return `tf_rdata`.
- R11: A write on the forwarding path of R10 while `pwr_down` is 1 makes `wake` high for one cycle on the next cycle. Reads, data, features and control writes, or writes with `pwr_down` at 0 leave `wake` low.
- R12: In modes 2 and 3, offsets outside both windows pass through untranslated and are then steered as any other translated offset.
- R13: After reset `devctl` is 0 and `soft_rst` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access offset within the card window |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Read data returned to the host |
| map_mode | input | 2 | Addressing mode: 0 memory, 1 contiguous I/O, 2 primary, 3 secondary |
| pwr_down | input | 1 | Power-down status bit from the status owner |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Current drive status byte |
| drv_sel | input | 1 | Drive-select bit |
| tf_rdata | input | 16 | Task-file read data |
| tf_reg | output | 3 | Task-file register index |
| tf_rd | output | 1 | Task-file register read strobe |
| tf_wr | output | 1 | Task-file register write strobe |
| tf_data_rd | output | 1 | 16-bit data-port read strobe |
| tf_data_wr | output | 1 | 16-bit data-port write strobe |
| tf_wdata | output | 16 | Write data toward the task-file |
| devctl | output | 8 | Device-control register |
| soft_rst | output | 1 | One-cycle soft-reset request |
| wake | output | 1 | One-cycle wake-from-power-down request |

## Verification
The assertions assume a host access lasts one cycle per `acc_valid` beat. They also assume the mode, power-down and drive inputs are steady while the beat is sampled. The stimulus meets this by changing every input only on the falling edge, one access per cycle.

Every offset of the 11-bit window is read in all four modes, and each result is compared against an arithmetic model of the translation. Directed writes then cover device control, soft reset, wake and the untranslated fall-through offsets with the power-down and drive inputs varied.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

   typedef enum logic [1:0] {
      MAP_MEM  = 2'd0,
      MAP_IO16 = 2'd1,
      MAP_PRI  = 2'd2,
      MAP_SEC  = 2'd3
   } map_mode_e;

   typedef enum logic [2:0] {
      RT_DATA,
      RT_ERRFEAT,
      RT_ALTCTL,
      RT_DEVADDR,
      RT_TASK
   } route_e;

   localparam logic [3:0] IDX_DATA_EVEN = 4'h0;
   localparam logic [3:0] IDX_DATA_ODD  = 4'h8;
   localparam logic [3:0] IDX_ERRFEAT   = 4'hD;
   localparam logic [3:0] IDX_ALTCTL    = 4'hE;
   localparam logic [3:0] IDX_DEVADDR   = 4'hF;

   localparam logic [2:0] TF_ERRFEAT_REG = 3'd1;
   localparam int         SRST_BIT       = 2;
   localparam logic [7:0] DEVADDR_FIXED  = 8'hC2;
   localparam logic [7:0] DEVADDR_MASK   = 8'h3C;

endpackage

// File: rtl/cfr_window_map.sv
module cfr_window_map
   import cfr_pkg::*;
#(
   parameter int ADDR_W         = 11,
   parameter int ALIAS_BASE     = 'h400,
   parameter int ALIAS_SPAN_W   = 10,
   parameter int PRI_CMD_BASE   = 'h1F0,
   parameter int PRI_CTL_BASE   = 'h3F0,
   parameter int SEC_CMD_BASE   = 'h170,
   parameter int SEC_CTL_BASE   = 'h370,
   parameter int CTL_IDX_OFFSET = 8
) (
   input  map_mode_e         mode,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] xlat
);

   localparam int WIN_W = 4;
   localparam int NLEG  = 2;
   localparam logic [ADDR_W-1:0] ALIAS_A = ADDR_W'(ALIAS_BASE);

   initial begin
      assert (ADDR_W >= 11) else $error("ADDR_W too small for the legacy windows");
      assert (ALIAS_SPAN_W < ADDR_W) else $error("alias span exceeds address width");
      assert ((PRI_CMD_BASE % 16) == 0 && (PRI_CTL_BASE % 16) == 0 &&
              (SEC_CMD_BASE % 16) == 0 && (SEC_CTL_BASE % 16) == 0)
         else $error("port windows must be 16-byte aligned");
      assert (CTL_IDX_OFFSET < 16) else $error("control index offset out of range");
   end

   logic              alias_hit;
   logic [NLEG-1:0]   cmd_hit;
   logic [NLEG-1:0]   ctl_hit;
   logic [ADDR_W-1:0] leg_xlat [NLEG];

   assign alias_hit = (addr[ADDR_W-1:ALIAS_SPAN_W] == ALIAS_A[ADDR_W-1:ALIAS_SPAN_W]);

   for (genvar g = 0; g < NLEG; g++) begin : g_leg
      localparam int CMD_I = (g == 0) ? PRI_CMD_BASE : SEC_CMD_BASE;
      localparam int CTL_I = (g == 0) ? PRI_CTL_BASE : SEC_CTL_BASE;
      localparam logic [ADDR_W-1:0] CMD_A   = ADDR_W'(CMD_I);
      localparam logic [ADDR_W-1:0] CTL_A   = ADDR_W'(CTL_I);
      localparam logic [ADDR_W-1:0] CTL_SUB = ADDR_W'(CTL_I - CTL_IDX_OFFSET);

      assign cmd_hit[g] = (addr[ADDR_W-1:WIN_W] == CMD_A[ADDR_W-1:WIN_W]);
      assign ctl_hit[g] = (addr[ADDR_W-1:WIN_W] == CTL_A[ADDR_W-1:WIN_W]);

      always_comb begin
         if (ctl_hit[g])
            leg_xlat[g] = addr - CTL_SUB;
         else if (cmd_hit[g])
            leg_xlat[g] = addr - CMD_A;
         else
            leg_xlat[g] = addr;
      end
   end

   always_comb begin
      unique case (mode)
         MAP_MEM:  xlat = alias_hit ? '0 : addr;
         MAP_IO16: xlat = {{(ADDR_W-WIN_W){1'b0}}, addr[WIN_W-1:0]};
         MAP_PRI:  xlat = leg_xlat[0];
         MAP_SEC:  xlat = leg_xlat[1];
         default:  xlat = addr;
      endcase
   end

endmodule

// File: rtl/cfr_route_decode.sv
module cfr_route_decode
   import cfr_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int TF_W   = 3
) (
   input  logic [ADDR_W-1:0] xlat,
   output route_e            route,
   output logic [TF_W-1:0]   reg_idx
);

   localparam int IDX_W = 4;

   initial begin
      assert (TF_W <= IDX_W) else $error("task-file index wider than the local index");
   end

   logic in_local;

   assign in_local = (xlat[ADDR_W-1:IDX_W] == '0);
   assign reg_idx  = xlat[TF_W-1:0];

   always_comb begin
      route = RT_TASK;
      if (in_local) begin
         unique case (xlat[IDX_W-1:0])
            IDX_DATA_EVEN, IDX_DATA_ODD: route = RT_DATA;
            IDX_ERRFEAT:                 route = RT_ERRFEAT;
            IDX_ALTCTL:                  route = RT_ALTCTL;
            IDX_DEVADDR:                 route = RT_DEVADDR;
            default:                     route = RT_TASK;
         endcase
      end
   end

endmodule

// File: rtl/cfr_ctrl_regs.sv
module cfr_ctrl_regs
   import cfr_pkg::*;
#(
   parameter int CTL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             wake_req,
   output logic [CTL_W-1:0] devctl,
   output logic             soft_rst,
   output logic             wake
);

   initial begin
      assert (CTL_W > SRST_BIT) else $error("control register lacks a reset bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         devctl   <= '0;
         soft_rst <= 1'b0;
         wake     <= 1'b0;
      end else begin
         if (ctl_wr)
            devctl <= ctl_wdata;
         soft_rst <= ctl_wr & ctl_wdata[SRST_BIT];
         wake     <= wake_req;
      end
   end

   p_devctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> devctl == $past(ctl_wdata));

   p_devctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(devctl));

   p_srst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[SRST_BIT]) |=> soft_rst);

   p_srst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> !soft_rst);

endmodule

// File: rtl/cfr_remap.sv
module cfr_remap
   import cfr_pkg::*;
#(
   parameter int ADDR_W         = 11,
   parameter int DATA_W         = 16,
   parameter int TF_W           = 3,
   parameter int STAT_W         = 8,
   parameter int PRI_CMD_BASE   = 'h1F0,
   parameter int PRI_CTL_BASE   = 'h3F0,
   parameter int SEC_CMD_BASE   = 'h170,
   parameter int SEC_CTL_BASE   = 'h370
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic [1:0]        map_mode,
   input  logic              pwr_down,
   input  logic              drv_present,
   input  logic [STAT_W-1:0] drv_status,
   input  logic              drv_sel,
   input  logic [DATA_W-1:0] tf_rdata,
   output logic [TF_W-1:0]   tf_reg,
   output logic              tf_rd,
   output logic              tf_wr,
   output logic              tf_data_rd,
   output logic              tf_data_wr,
   output logic [DATA_W-1:0] tf_wdata,
   output logic [7:0]        devctl,
   output logic              soft_rst,
   output logic              wake
);

   localparam int BYTE_W = 8;

   initial begin
      assert (DATA_W >= BYTE_W && STAT_W <= DATA_W) else $error("data path too narrow");
   end

   logic [ADDR_W-1:0] xlat;
   route_e            route;
   logic [TF_W-1:0]   reg_idx;
   logic              is_rd;
   logic              is_wr;
   logic              ctl_wr;
   logic              wake_req;
   logic [BYTE_W-1:0] inv_sel;
   logic [BYTE_W-1:0] devaddr_byte;

   cfr_window_map #(
      .ADDR_W       (ADDR_W),
      .PRI_CMD_BASE (PRI_CMD_BASE),
      .PRI_CTL_BASE (PRI_CTL_BASE),
      .SEC_CMD_BASE (SEC_CMD_BASE),
      .SEC_CTL_BASE (SEC_CTL_BASE)
   ) u_map (
      .mode (map_mode_e'(map_mode)),
      .addr (acc_addr),
      .xlat (xlat)
   );

   cfr_route_decode #(
      .ADDR_W (ADDR_W),
      .TF_W   (TF_W)
   ) u_route (
      .xlat    (xlat),
      .route   (route),
      .reg_idx (reg_idx)
   );

   assign is_rd = acc_valid & ~acc_write;
   assign is_wr = acc_valid &  acc_write;

   // Writes to the device-address slot fall through to the task-file path.
   logic fwd_path;
   assign fwd_path = (route == RT_TASK) | (route == RT_DEVADDR);

   assign ctl_wr   = is_wr & (route == RT_ALTCTL);
   assign wake_req = is_wr & fwd_path & pwr_down;

   assign tf_data_rd = is_rd & (route == RT_DATA);
   assign tf_data_wr = is_wr & (route == RT_DATA);
   assign tf_rd      = is_rd & ((route == RT_ERRFEAT) | (route == RT_TASK));
   assign tf_wr      = is_wr & ((route == RT_ERRFEAT) | fwd_path);
   assign tf_wdata   = acc_wdata;

   always_comb begin
      unique case (route)
         RT_ERRFEAT:         tf_reg = TF_ERRFEAT_REG;
         RT_TASK, RT_DEVADDR: tf_reg = reg_idx;
         default:            tf_reg = '0;
      endcase
   end

   assign inv_sel      = ~{{(BYTE_W-1){1'b0}}, drv_sel};
   assign devaddr_byte = DEVADDR_FIXED | ((inv_sel << 2) & DEVADDR_MASK);

   always_comb begin
      unique case (route)
         RT_ALTCTL:  acc_rdata = drv_present ? DATA_W'(drv_status) : '0;
         RT_DEVADDR: acc_rdata = DATA_W'(devaddr_byte);
         default:    acc_rdata = tf_rdata;
      endcase
   end

   cfr_ctrl_regs #(
      .CTL_W (BYTE_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (acc_wdata[BYTE_W-1:0]),
      .wake_req  (wake_req),
      .devctl    (devctl),
      .soft_rst  (soft_rst),
      .wake      (wake)
   );

   p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tf_rd, tf_wr, tf_data_rd, tf_data_wr}));

   p_alt_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && route == RT_ALTCTL)
         |-> !(tf_rd || tf_wr || tf_data_rd || tf_data_wr));

   p_errfeat_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && route == RT_ERRFEAT) |-> (tf_reg == TF_ERRFEAT_REG));

   p_wake_fires_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && pwr_down && route == RT_TASK) |=> wake);

   p_wake_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |=> !wake);

   p_devaddr_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && route == RT_DEVADDR)
         |-> (acc_rdata[7:0] == (drv_sel ? 8'hFA : 8'hFE)));

endmodule

// File: tb/test_cfr_remap.sv
module test_cfr_remap;

   localparam int  ADDR_W = 11;
   localparam real CLK_NS = 4.0;
   localparam logic [15:0] TF_PAT = 16'hBEEF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [15:0]       acc_wdata = '0;
   logic [15:0]       acc_rdata;
   logic [1:0]        map_mode = 2'd0;
   logic              pwr_down = 1'b0;
   logic              drv_present = 1'b1;
   logic [7:0]        drv_status = 8'h5A;
   logic              drv_sel = 1'b0;
   logic [15:0]       tf_rdata = TF_PAT;
   logic [2:0]        tf_reg;
   logic              tf_rd, tf_wr, tf_data_rd, tf_data_wr;
   logic [15:0]       tf_wdata;
   logic [7:0]        devctl;
   logic              soft_rst, wake;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   cfr_remap i_cfr_remap (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .map_mode(map_mode), .pwr_down(pwr_down), .drv_present(drv_present),
      .drv_status(drv_status), .drv_sel(drv_sel), .tf_rdata(tf_rdata),
      .tf_reg(tf_reg), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_data_rd(tf_data_rd),
      .tf_data_wr(tf_data_wr), .tf_wdata(tf_wdata), .devctl(devctl),
      .soft_rst(soft_rst), .wake(wake)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(bit wr, int mode, int addr, logic [15:0] wd);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = wr;
      map_mode  = 2'(mode);
      acc_addr  = ADDR_W'(addr);
      acc_wdata = wd;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
      #1;
   endtask

   function automatic int exp_xlat(int mode, int a);
      case (mode)
         0: return ((a >> 10) == 1) ? 0 : a;
         1: return a & 15;
         2: return ((a >> 4) == 'h3F) ? a - 'h3E8 : ((a >> 4) == 'h1F) ? a - 'h1F0 : a;
         default: return ((a >> 4) == 'h37) ? a - 'h368 : ((a >> 4) == 'h17) ? a - 'h170 : a;
      endcase
   endfunction

   // packed read view: {tf_rd, tf_data_rd, tf_wr, tf_data_wr, reg(only when tf_rd/tf_wr), rdata}
   function automatic logic [31:0] rd_view();
      logic [2:0] r;
      r = (tf_rd | tf_wr) ? tf_reg : 3'd0;
      return {9'd0, tf_rd, tf_data_rd, tf_wr, tf_data_wr, r, acc_rdata};
   endfunction

   function automatic logic [31:0] exp_rd_view(int t);
      if (t == 0 || t == 8)  return {9'd0, 4'b0100, 3'd0, TF_PAT};
      if (t == 'hD)          return {9'd0, 4'b1000, 3'd1, TF_PAT};
      if (t == 'hE)          return {9'd0, 4'b0000, 3'd0, 8'h00, drv_status};
      if (t == 'hF)          return {9'd0, 4'b0000, 3'd0, 16'h00FE};
      return {9'd0, 4'b1000, 3'(t & 7), TF_PAT};
   endfunction

   function automatic logic [31:0] wr_view();
      logic [2:0] r;
      r = (tf_rd | tf_wr) ? tf_reg : 3'd0;
      return {25'd0, tf_rd, tf_data_rd, tf_wr, tf_data_wr, r};
   endfunction

   initial begin
      #(CLK_NS * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      string tags[4];
      tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4";

      repeat (3) @(negedge clk);
      #1;
      // R13: reset state
      check("R13", {24'd0, devctl}, 32'h0, "devctl after reset");
      check("R13", {31'd0, soft_rst}, 32'h0, "soft_rst after reset");
      check("R13", {31'd0, wake}, 32'h0, "wake after reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1..R4 sweep: every offset in every mode, read side
      for (int m = 0; m < 4; m++) begin
         for (int a = 0; a < (1 << ADDR_W); a++) begin
            drive(1'b0, m, a, 16'h0);
            check(tags[m], rd_view(), exp_rd_view(exp_xlat(m, a)), $sformatf("read offset %0h", a));
         end
      end
      idle();

      // R5: data port write and read
      drive(1'b1, 1, 8, 16'h1234);
      check("R5", wr_view(), {25'd0, 4'b0001, 3'd0}, "data write strobes");
      check("R5", {16'd0, tf_wdata}, 32'h1234, "data write value");
      drive(1'b0, 0, 'h5A3, 16'h0);
      check("R5", rd_view(), {9'd0, 4'b0100, 3'd0, TF_PAT}, "aliased data read");

      // R6: features write
      pwr_down = 1'b1;
      drive(1'b1, 1, 'hD, 16'h0077);
      check("R6", wr_view(), {25'd0, 4'b0010, 3'd1}, "features write");
      idle();
      check("R11", {31'd0, wake}, 32'h0, "no wake after features write");

      // R7: no drive present
      drive_present_off();
      drive(1'b0, 2, 'h3F6, 16'h0);
      check("R7", rd_view(), 32'h0, "alt status without drive");
      drv_present = 1'b1;

      // R9: drive select 1
      drv_sel = 1'b1;
      drive(1'b0, 3, 'h377, 16'h0);
      check("R9", rd_view(), {9'd0, 4'b0000, 3'd0, 16'h00FA}, "device address sel=1");
      drv_sel = 1'b0;

      // R8: device control write with soft reset bit
      drive(1'b1, 1, 'hE, 16'h0004);
      check("R8", wr_view(), 32'h0, "control write raises no strobe");
      idle();
      check("R8", {24'd0, devctl}, 32'h04, "devctl loaded");
      check("R8", {31'd0, soft_rst}, 32'h1, "soft reset pulse");
      check("R11", {31'd0, wake}, 32'h0, "no wake after control write");
      @(negedge clk); #1;
      check("R8", {31'd0, soft_rst}, 32'h0, "soft reset pulse ends");
      check("R8", {24'd0, devctl}, 32'h04, "devctl holds");
      drive(1'b1, 2, 'h3F6, 16'h0002);
      idle();
      check("R8", {24'd0, devctl}, 32'h02, "devctl via primary control port");
      check("R8", {31'd0, soft_rst}, 32'h0, "no soft reset without bit 2");

      // R10/R11: forwarding writes with power-down
      drive(1'b1, 1, 3, 16'h00AB);
      check("R10", wr_view(), {25'd0, 4'b0010, 3'd3}, "task-file write index 3");
      idle();
      check("R11", {31'd0, wake}, 32'h1, "wake after task-file write");
      @(negedge clk); #1;
      check("R11", {31'd0, wake}, 32'h0, "wake is one cycle");
      drive(1'b1, 1, 'hF, 16'h00A0);
      check("R10", wr_view(), {25'd0, 4'b0010, 3'd7}, "write at device address slot");
      idle();
      check("R11", {31'd0, wake}, 32'h1, "wake after slot-F write");
      drive(1'b1, 1, 0, 16'h5555);
      idle();
      check("R11", {31'd0, wake}, 32'h0, "no wake after data write");
      drive(1'b0, 1, 3, 16'h0);
      idle();
      check("R11", {31'd0, wake}, 32'h0, "no wake after read");
      pwr_down = 1'b0;
      drive(1'b1, 1, 3, 16'h0);
      idle();
      check("R11", {31'd0, wake}, 32'h0, "no wake when powered up");

      // R12: untranslated offsets in legacy modes
      drive(1'b1, 2, 'h00D, 16'h0011);
      check("R12", wr_view(), {25'd0, 4'b0010, 3'd1}, "mode 2 raw offset D");
      drive(1'b0, 3, 'h1F6, 16'h0);
      check("R12", rd_view(), {9'd0, 4'b1000, 3'd6, TF_PAT}, "mode 3 primary offset");
      drive(1'b0, 2, 'h3F9, 16'h0);
      check("R3", rd_view(), {9'd0, 4'b1000, 3'd1, TF_PAT}, "primary ctl beyond slot F");
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   task automatic drive_present_off();
      drv_present = 1'b0;
   endtask

endmodule